// File: doc/BRIEF.md
# Event-Coded Trigger Output Generator

This block sits on the receive side of a timing distribution link. It takes already-decoded event codes, one byte per event-clock cycle with a valid strobe, and turns them into timed trigger pulses on seven outputs. Channels 0 to 4 drive the TTL-class group and channels 5 and 6 drive the LVPECL-class group. Both groups are modelled here as plain logic outputs. Each channel watches for its own event code. When that code arrives, the channel waits its programmed delay and then drives its output high for its programmed width. Delay and width are counted in event-clock cycles.

Settings are double-buffered. A configuration port writes a shadow copy of each channel's code, delay, width and enable. A load strobe then moves the shadow copy into the active copy. A channel that is busy delaying or pulsing keeps its active settings until it returns to idle. This lets the per-pulse pattern retune delays and enables once per machine pulse without cutting short a pulse that is already in flight. A code that repeats while its channel is busy is dropped, and the drop is reported on a sticky per-channel overrun flag.

Top module: `trig_event_out`

## Requirements
- R1: After reset every output is low and every overrun flag is clear. Every channel's active settings are zero (code 0, delay 0, width 0, disabled), so no code starts a pulse until settings are loaded.
- R2: A channel starts only on a cycle where code_valid_i is high and code_i equals the channel's active code. A matching byte with code_valid_i low has no effect.
- R3: If a code is accepted at clock edge E, the channel output is high from just after edge E+delay for exactly width cycles, then low again.
- R4: Channels are independent. One code may start several channels, each with its own delay and width. Channel n for n<5 drives trig_ttl_o[n], and channel n for n>=5 drives trig_pecl_o[n-5].
- R5: A configuration write with cfg_we_i high updates only the shadow settings of channel cfg_ch_i. cfg_sel_i selects the field: 0 = code (low 8 data bits), 1 = delay, 2 = width, 3 = enable (data bit 0). Shadow values have no effect until a load.
- R6: On a load_i edge, every idle channel copies shadow to active at that edge. A busy channel keeps its active settings until its pulse ends, then applies the load at the first edge where it is idle.
- R7: A channel whose active width is zero produces no pulse and stays idle, so codes sent to it never set its overrun flag.
- R8: A matching code that arrives while the channel is delaying or pulsing is ignored. It sets the channel's overrun_o bit, which stays set until reset.
- R9: A disabled channel keeps its output low, ignores its code and never sets its overrun flag.
- R10: When load_i and an accepted code fall on the same edge for an idle channel, the code is timed with the newly loaded settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Event clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_i | input | 8 | Decoded event code |
| code_valid_i | input | 1 | code_i holds an event this cycle |
| cfg_we_i | input | 1 | Shadow settings write strobe |
| cfg_ch_i | input | 3 | Channel addressed by the write |
| cfg_sel_i | input | 2 | Field select: 0 code, 1 delay, 2 width, 3 enable |
| cfg_data_i | input | 32 | Write data |
| load_i | input | 1 | Move shadow settings to active (per-channel safe point) |
| trig_ttl_o | output | 5 | Trigger outputs of channels 0 to 4 |
| trig_pecl_o | output | 2 | Trigger outputs of channels 5 and 6 |
| overrun_o | output | 7 | Sticky retrigger-while-busy flags, one per channel |

## Verification
The bench targets the edges of the delay and width counting. It uses a zero delay, a one-cycle width and a long delay. A design that is off by one register stage shifts every pulse start or length by a cycle, and the scoreboard reports that against the expected rise cycle. It reloads a channel in the middle of a pulse. A design that applies the load at once would stretch or shorten that pulse, and a design that drops the pending load would keep the old delay on the next event. It also sends a code on the same edge as a load, repeats a code while its channel is busy, and sends codes to a zero-width channel and to a disabled channel. A design that mishandles these would use stale settings, emit a second pulse, raise a false overrun, or pulse a channel that should stay silent.

// File: rtl/trig_event_out_pkg.sv
package trig_event_out_pkg;

  typedef enum logic [1:0] {
    SEL_CODE  = 2'd0,
    SEL_DELAY = 2'd1,
    SEL_WIDTH = 2'd2,
    SEL_EN    = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_PULSE = 2'd2
  } ch_state_e;

endpackage

// File: rtl/trig_cfg_bank.sv
module trig_cfg_bank
  import trig_event_out_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        sel_i,
  input  logic [CNT_W-1:0]  data_i,
  input  logic              load_i,
  input  logic              busy_i,
  output logic [CODE_W-1:0] eff_code_o,
  output logic [CNT_W-1:0]  eff_delay_o,
  output logic [CNT_W-1:0]  eff_width_o,
  output logic              eff_en_o,
  output logic [CODE_W-1:0] act_code_o,
  output logic [CNT_W-1:0]  act_delay_o,
  output logic [CNT_W-1:0]  act_width_o,
  output logic              act_en_o
);

  logic [CODE_W-1:0] shd_code_q, act_code_q;
  logic [CNT_W-1:0]  shd_delay_q, act_delay_q;
  logic [CNT_W-1:0]  shd_width_q, act_width_q;
  logic              shd_en_q, act_en_q;
  logic              pend_q;
  logic              apply;

  // a load waits for the channel to go idle
  assign apply = (load_i | pend_q) & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_code_q  <= '0;
      shd_delay_q <= '0;
      shd_width_q <= '0;
      shd_en_q    <= 1'b0;
    end else if (wr_i) begin
      unique case (cfg_sel_e'(sel_i))
        SEL_CODE:  shd_code_q  <= data_i[CODE_W-1:0];
        SEL_DELAY: shd_delay_q <= data_i;
        SEL_WIDTH: shd_width_q <= data_i;
        SEL_EN:    shd_en_q    <= data_i[0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_code_q  <= '0;
      act_delay_q <= '0;
      act_width_q <= '0;
      act_en_q    <= 1'b0;
      pend_q      <= 1'b0;
    end else if (apply) begin
      act_code_q  <= shd_code_q;
      act_delay_q <= shd_delay_q;
      act_width_q <= shd_width_q;
      act_en_q    <= shd_en_q;
      pend_q      <= 1'b0;
    end else if (load_i) begin
      pend_q <= 1'b1;
    end
  end

  // settings seen by the channel this cycle
  always_comb begin
    if (apply) begin
      eff_code_o  = shd_code_q;
      eff_delay_o = shd_delay_q;
      eff_width_o = shd_width_q;
      eff_en_o    = shd_en_q;
    end else begin
      eff_code_o  = act_code_q;
      eff_delay_o = act_delay_q;
      eff_width_o = act_width_q;
      eff_en_o    = act_en_q;
    end
  end

  assign act_code_o  = act_code_q;
  assign act_delay_o = act_delay_q;
  assign act_width_o = act_width_q;
  assign act_en_o    = act_en_q;

endmodule

// File: rtl/trig_pulse_chan.sv
module trig_pulse_chan
  import trig_event_out_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              code_valid_i,
  input  logic [CODE_W-1:0] cfg_code_i,
  input  logic [CNT_W-1:0]  cfg_delay_i,
  input  logic [CNT_W-1:0]  cfg_width_i,
  input  logic              cfg_en_i,
  output logic              trig_o,
  output logic              busy_o,
  output logic              overrun_o
);

  ch_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             trig_q;
  logic             ovr_q;
  logic             hit;

  assign hit = code_valid_i && (code_i == cfg_code_i) && cfg_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      trig_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (hit && (cfg_width_i != '0)) begin
            if (cfg_delay_i == '0) begin
              state_q <= ST_PULSE;
              cnt_q   <= cfg_width_i - 1'b1;
              trig_q  <= 1'b1;
            end else begin
              state_q <= ST_DELAY;
              cnt_q   <= cfg_delay_i - 1'b1;
            end
          end
        end
        ST_DELAY: begin
          if (cnt_q == '0) begin
            state_q <= ST_PULSE;
            cnt_q   <= cfg_width_i - 1'b1;
            trig_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_PULSE: begin
          if (cnt_q == '0) begin
            state_q <= ST_IDLE;
            trig_q  <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          trig_q  <= 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovr_q <= 1'b0;
    else if (hit && (state_q != ST_IDLE)) ovr_q <= 1'b1;
  end

  assign trig_o    = trig_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign overrun_o = ovr_q;

endmodule

// File: rtl/trig_event_out.sv
module trig_event_out #(
  parameter int NUM_CH  = 7,
  parameter int NUM_TTL = 5,
  parameter int CODE_W  = 8,
  parameter int CNT_W   = 32,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int NUM_PECL = NUM_CH - NUM_TTL
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CODE_W-1:0]   code_i,
  input  logic                code_valid_i,
  input  logic                cfg_we_i,
  input  logic [CH_W-1:0]     cfg_ch_i,
  input  logic [1:0]          cfg_sel_i,
  input  logic [CNT_W-1:0]    cfg_data_i,
  input  logic                load_i,
  output logic [NUM_TTL-1:0]  trig_ttl_o,
  output logic [NUM_PECL-1:0] trig_pecl_o,
  output logic [NUM_CH-1:0]   overrun_o
);

  logic [NUM_CH-1:0]             trig_all;
  logic [NUM_CH-1:0]             busy;
  logic [NUM_CH-1:0]             eff_en;
  logic [NUM_CH-1:0]             act_en;
  logic [NUM_CH-1:0][CODE_W-1:0] eff_code;
  logic [NUM_CH-1:0][CODE_W-1:0] act_code;
  logic [NUM_CH-1:0][CNT_W-1:0]  eff_delay;
  logic [NUM_CH-1:0][CNT_W-1:0]  act_delay;
  logic [NUM_CH-1:0][CNT_W-1:0]  eff_width;
  logic [NUM_CH-1:0][CNT_W-1:0]  act_width;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic wr;
    assign wr = cfg_we_i && (cfg_ch_i == CH_W'(i));

    trig_cfg_bank #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_cfg (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (wr),
      .sel_i       (cfg_sel_i),
      .data_i      (cfg_data_i),
      .load_i      (load_i),
      .busy_i      (busy[i]),
      .eff_code_o  (eff_code[i]),
      .eff_delay_o (eff_delay[i]),
      .eff_width_o (eff_width[i]),
      .eff_en_o    (eff_en[i]),
      .act_code_o  (act_code[i]),
      .act_delay_o (act_delay[i]),
      .act_width_o (act_width[i]),
      .act_en_o    (act_en[i])
    );

    trig_pulse_chan #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chan (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .code_i       (code_i),
      .code_valid_i (code_valid_i),
      .cfg_code_i   (eff_code[i]),
      .cfg_delay_i  (eff_delay[i]),
      .cfg_width_i  (eff_width[i]),
      .cfg_en_i     (eff_en[i]),
      .trig_o       (trig_all[i]),
      .busy_o       (busy[i]),
      .overrun_o    (overrun_o[i])
    );
  end

  assign trig_ttl_o  = trig_all[NUM_TTL-1:0];
  assign trig_pecl_o = trig_all[NUM_CH-1:NUM_TTL];

endmodule

// File: rtl/trig_event_out_chk.sv
module trig_event_out_chk #(
  parameter int NUM_CH = 7,
  parameter int CODE_W = 8,
  parameter int CNT_W  = 32
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [NUM_CH-1:0]               trig_i,
  input logic [NUM_CH-1:0]               busy_i,
  input logic [NUM_CH-1:0]               overrun_i,
  input logic [NUM_CH-1:0]               act_en_i,
  input logic [NUM_CH-1:0][CODE_W-1:0]   act_code_i,
  input logic [NUM_CH-1:0][CNT_W-1:0]    act_delay_i,
  input logic [NUM_CH-1:0][CNT_W-1:0]    act_width_i
);

  logic [NUM_CH-1:0][CNT_W-1:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_cnt_q <= '0;
    else begin
      for (int i = 0; i < NUM_CH; i++)
        hi_cnt_q[i] <= trig_i[i] ? hi_cnt_q[i] + 1'b1 : '0;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    assert_pulse_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(trig_i[i]) |-> (hi_cnt_q[i] == act_width_i[i]));

    assert_high_only_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_i[i] |-> busy_i[i]);

    assert_active_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_i[i] |=> ($stable(act_width_i[i]) && $stable(act_delay_i[i]) &&
                     $stable(act_code_i[i]) && $stable(act_en_i[i])));

    assert_overrun_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      overrun_i[i] |=> overrun_i[i]);

    assert_rise_enabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(trig_i[i]) |-> act_en_i[i]);
  end

endmodule

bind trig_event_out trig_event_out_chk #(
  .NUM_CH (NUM_CH),
  .CODE_W (CODE_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .trig_i      (trig_all),
  .busy_i      (busy),
  .overrun_i   (overrun_o),
  .act_en_i    (act_en),
  .act_code_i  (act_code),
  .act_delay_i (act_delay),
  .act_width_i (act_width)
);

// File: tb/trig_event_out_test.sv
`timescale 1ns/1ps
module trig_event_out_test;
  localparam int NCH = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0]  code;
  logic        code_valid, cfg_we, load;
  logic [2:0]  cfg_ch;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_data;
  logic [4:0]  ttl;
  logic [1:0]  pecl;
  logic [6:0]  ovr;
  wire  [6:0]  trig = {pecl, ttl};

  trig_event_out uut (
    .clk_i(clk), .rst_ni(rst_n), .code_i(code), .code_valid_i(code_valid),
    .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
    .load_i(load), .trig_ttl_o(ttl), .trig_pecl_o(pecl), .overrun_o(ovr)
  );

  typedef struct {
    int     ch;
    longint rise;
    longint width;
    string  req;
  } exp_t;

  exp_t   exp_q[$];
  longint cyc = 0;
  longint last_fire = 0;
  int     checks = 0;
  int     errors = 0;
  int     pulse_cnt[NCH];
  longint rise_at[NCH];
  logic [6:0] prev = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic match_pulse(input int c, input longint rise, input longint width);
    bit found = 1'b0;
    for (int k = 0; k < exp_q.size(); k++) begin
      if (!found && exp_q[k].ch == c) begin
        check(rise == exp_q[k].rise, exp_q[k].req, $sformatf("ch%0d rise cycle", c),
              rise, exp_q[k].rise);
        check(width == exp_q[k].width, exp_q[k].req, $sformatf("ch%0d width", c),
              width, exp_q[k].width);
        exp_q.delete(k);
        found = 1'b1;
      end
    end
    if (!found) check(1'b0, "R4", $sformatf("unexpected pulse ch%0d at", c), rise, -1);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        if (trig[c] && !prev[c]) begin
          rise_at[c] = cyc;
          pulse_cnt[c]++;
        end
        if (!trig[c] && prev[c]) match_pulse(c, rise_at[c], cyc - rise_at[c]);
      end
    end
    prev = trig;
  end

  task automatic cfg_write(input int ch, input int sel, input longint data);
    cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_sel = 2'(sel); cfg_data = 32'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input int ch, input int c, input int dly, input int wid, input int en);
    cfg_write(ch, 0, c);
    cfg_write(ch, 1, dly);
    cfg_write(ch, 2, wid);
    cfg_write(ch, 3, en);
  endtask

  task automatic do_load();
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic fire(input int c, input bit with_load, input bit valid);
    code = 8'(c); code_valid = valid; load = with_load;
    last_fire = cyc;
    @(negedge clk);
    code_valid = 1'b0; load = 1'b0;
  endtask

  task automatic expect_p(input int ch, input int dly, input int wid, input string req);
    exp_t e;
    e.ch = ch; e.rise = last_fire + 1 + dly; e.width = wid; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog", "run did not finish, cycle", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int pc;
    code = '0; code_valid = 1'b0; cfg_we = 1'b0; load = 1'b0;
    cfg_ch = '0; cfg_sel = '0; cfg_data = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1: reset state, code 0 must not start a disabled channel
    check(trig == 7'h0, "R1", "outputs after reset", trig, 0);
    check(ovr == 7'h0, "R1", "overrun after reset", ovr, 0);
    fire(8'h00, 1'b0, 1'b1);
    idle(5);
    check(pulse_cnt[0] == 0, "R1", "pulses after code 0", pulse_cnt[0], 0);

    // R3: basic delay/width
    setup(0, 8'h10, 5, 3, 1);
    do_load();
    fire(8'h10, 1'b0, 1'b1); expect_p(0, 5, 3, "R3");
    idle(12);

    // R4: one code, three channels across both groups
    setup(1, 8'h20, 0, 1, 1);
    setup(2, 8'h20, 10, 4, 1);
    setup(6, 8'h20, 2, 7, 1);
    do_load();
    fire(8'h20, 1'b0, 1'b1);
    expect_p(1, 0, 1, "R4"); expect_p(2, 10, 4, "R4"); expect_p(6, 2, 7, "R4");
    idle(20);

    // R2: matching byte with valid low
    pc = pulse_cnt[0];
    fire(8'h10, 1'b0, 1'b0);
    idle(10);
    check(pulse_cnt[0] == pc, "R2", "pulse with valid low", pulse_cnt[0], pc);
    // R2: non-matching code
    fire(8'h11, 1'b0, 1'b1);
    idle(10);
    check(pulse_cnt[0] == pc, "R2", "pulse on wrong code", pulse_cnt[0], pc);

    // R5: shadow write without load keeps old delay
    cfg_write(0, 1, 20);
    fire(8'h10, 1'b0, 1'b1); expect_p(0, 5, 3, "R5");
    idle(12);
    do_load();
    fire(8'h10, 1'b0, 1'b1); expect_p(0, 20, 3, "R5");
    idle(30);

    // R6: load during a pulse is held until idle
    fire(8'h10, 1'b0, 1'b1); expect_p(0, 20, 3, "R6");
    idle(3);
    cfg_write(0, 1, 2);
    do_load();
    idle(25);
    fire(8'h10, 1'b0, 1'b1); expect_p(0, 2, 3, "R6");
    idle(10);

    // R7: zero width
    setup(3, 8'h30, 1, 0, 1);
    do_load();
    fire(8'h30, 1'b0, 1'b1);
    fire(8'h30, 1'b0, 1'b1);
    idle(8);
    check(pulse_cnt[3] == 0, "R7", "pulses on zero width", pulse_cnt[3], 0);
    check(ovr[3] == 1'b0, "R7", "overrun on zero width", ovr[3], 0);

    // R8: retrigger while busy
    setup(4, 8'h40, 8, 2, 1);
    do_load();
    fire(8'h40, 1'b0, 1'b1); expect_p(4, 8, 2, "R8");
    idle(2);
    fire(8'h40, 1'b0, 1'b1);
    idle(15);
    check(pulse_cnt[4] == 1, "R8", "pulse count after retrigger", pulse_cnt[4], 1);
    check(ovr == 7'b0010000, "R8", "overrun vector", ovr, 7'b0010000);

    // R9: disabled channel
    setup(5, 8'h50, 1, 2, 0);
    do_load();
    fire(8'h50, 1'b0, 1'b1);
    fire(8'h50, 1'b0, 1'b1);
    idle(8);
    check(pulse_cnt[5] == 0, "R9", "pulses while disabled", pulse_cnt[5], 0);
    check(ovr[5] == 1'b0, "R9", "overrun while disabled", ovr[5], 0);

    // R10: load and code on the same edge
    cfg_write(5, 3, 1);
    cfg_write(5, 1, 1);
    fire(8'h50, 1'b1, 1'b1); expect_p(5, 1, 2, "R10");
    idle(10);

    // R8: flag remains set
    check(ovr[4] == 1'b1, "R8", "overrun sticky", ovr[4], 1);

    idle(5);
    check(exp_q.size() == 0, "R3", "expected pulses never seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule